// File: doc/BRIEF.md
# Coherence Race Arc Recorder

This unit sits beside one processor's cache controller and records the memory ordering across processors that a later deterministic replay needs. It counts committed instructions. For every cache block it remembers the count of the last local load or store to that block. When another processor asks for a block, the unit returns that count, and the coherence message carries it. The message type decides where the count rides. A write-to-read or write-to-write conflict uses the data response. A read-to-write conflict uses the invalidation acknowledgement.

When a coherence reply arrives from another processor, it carries the sender's ID and count, which form the start of an ordering arc. The unit pairs them with its own ID and its current count plus one. It writes that arc to a log port only if the arc is not already implied by an earlier one. To decide this, it keeps a vector that holds, for each other processor, the highest count received so far. A reply whose count is not above that entry is dropped. This transitive reduction keeps the log small. A full log stalls acceptance of further replies until the pending entry has been written.

The control is a three-state machine:
- `ST_IDLE` accepts a reply and moves to `ST_CMP` (transition *accept*).
- `ST_CMP` compares the reply against the vector. It moves to `ST_WRITE` when the arc is new (*keep*). Otherwise it returns to `ST_IDLE` (*prune*).
- `ST_WRITE` stays put while the log is full (*hold*). It returns to `ST_IDLE` once the entry is taken (*drain*).

Top module: `race_arc_rec`

## Requirements
- R1: After reset the instruction count, every block's last-access count and every vector entry are zero. A request to any block then returns count 0, `log_valid` is low and `rep_ready` is high.
- R2: Each cycle with `cmt_valid` high raises the instruction count by exactly one.
- R3: A commit with `cmt_is_mem` high writes the new, incremented count into the entry of block `cmt_blk`. A commit with `cmt_is_mem` low leaves every block entry unchanged.
- R4: A request (`req_valid`) is answered in the next cycle:
  - `rsp_valid` is high.
  - `rsp_cnt` equals the block's last-access count as it was at the request edge.
  - `rsp_is_ack` equals `req_inv` (1 = invalidation acknowledgement, 0 = data response).
- R5: A reply is taken on a cycle where both `rep_valid` and `rep_ready` are high. Its arc end count is the instruction count at that edge plus one.
- R6: A reply from another processor whose count is strictly greater than that processor's vector entry produces one log entry. The entry is then replaced by the reply count.
- R7: A reply whose count is equal to or below the vector entry produces no log entry and leaves the entry unchanged.
- R8: A reply whose source ID equals the local ID produces no log entry.
- R9: A log entry is packed, from the top bit down, as source ID, source count, local ID and destination count. Each ID is 2 bits and each count is 32 bits, which places the fields at [67:66], [65:34], [33:32] and [31:0].
- R10: While `log_full` is high, `log_valid` stays low, the pending entry is held unchanged and `rep_ready` stays low. The entry appears in the first cycle in which `log_full` is low.
- R11: With `log_full` low, `log_valid` is high in the second cycle after the accepting edge, for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmt_valid | input | 1 | One instruction committed this cycle |
| cmt_is_mem | input | 1 | Committed instruction was a load or store |
| cmt_blk | input | BLK_W | Block index of that load or store |
| req_valid | input | 1 | Coherence request from another processor |
| req_blk | input | BLK_W | Block index of the request |
| req_inv | input | 1 | Request is an invalidation (reply as acknowledgement) |
| rsp_valid | output | 1 | Outgoing reply count is valid |
| rsp_cnt | output | IC_W | Last-access count attached to the reply |
| rsp_is_ack | output | 1 | Count rides on the invalidation acknowledgement |
| rep_valid | input | 1 | Incoming coherence reply |
| rep_src | input | PID_W | Sender processor ID |
| rep_cnt | input | IC_W | Sender's count (arc start) |
| rep_ready | output | 1 | Reply can be accepted |
| log_full | input | 1 | Log cannot take an entry |
| log_valid | output | 1 | Log write strobe |
| log_data | output | LOG_W | Packed arc entry |

## Verification
The first pattern is commit streams that mix memory and non-memory instructions across every block, followed by a request to each block. This separates updates of the instruction count from updates of the block table, and data responses from acknowledgements. The second pattern sweeps replies from every source ID with counts above, equal to and below the running vector entry, including the all-ones count. This separates kept arcs from pruned ones and the local ID from remote IDs, and it checks the packed field order. The third pattern holds the log full during a kept arc, which separates a held entry from a dropped or duplicated one.

// File: rtl/race_arc_pkg.sv
package race_arc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CMP   = 2'd1,
        ST_WRITE = 2'd2
    } rec_state_e;
endpackage

// File: rtl/rar_icount.sv
module rar_icount #(
    parameter int IC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    output logic [IC_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (step) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/rar_blk_table.sv
module rar_blk_table #(
    parameter int NBLK = 16,
    parameter int IC_W = 32,
    localparam int BLK_W = $clog2(NBLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BLK_W-1:0] wr_blk,
    input  logic [IC_W-1:0]  wr_cnt,
    input  logic             rd_en,
    input  logic [BLK_W-1:0] rd_blk,
    output logic [IC_W-1:0]  rd_cnt
);
    logic [IC_W-1:0] last_q [NBLK];

    for (genvar b = 0; b < NBLK; b++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                last_q[b] <= '0;
            end else if (wr_en && (wr_blk == BLK_W'(b))) begin
                last_q[b] <= wr_cnt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt <= '0;
        end else if (rd_en) begin
            rd_cnt <= last_q[rd_blk];
        end
    end
endmodule

// File: rtl/rar_vec.sv
module rar_vec #(
    parameter int NPROC    = 4,
    parameter int IC_W     = 32,
    parameter int LOCAL_ID = 1,
    localparam int PID_W = $clog2(NPROC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PID_W-1:0] sel,
    input  logic             wr_en,
    input  logic [IC_W-1:0]  wr_cnt,
    output logic [IC_W-1:0]  rd_cnt
);
    logic [IC_W-1:0] seen [NPROC];

    for (genvar p = 0; p < NPROC; p++) begin : g_src
        if (p == LOCAL_ID) begin : g_self
            assign seen[p] = '0;
        end else begin : g_remote
            logic [IC_W-1:0] ent_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ent_q <= '0;
                end else if (wr_en && (sel == PID_W'(p))) begin
                    ent_q <= wr_cnt;
                end
            end
            assign seen[p] = ent_q;
        end
    end

    assign rd_cnt = seen[sel];
endmodule

// File: rtl/race_arc_rec.sv
module race_arc_rec
    import race_arc_pkg::*;
#(
    parameter int NPROC    = 4,
    parameter int NBLK     = 16,
    parameter int IC_W     = 32,
    parameter int LOCAL_ID = 1,
    localparam int PID_W = $clog2(NPROC),
    localparam int BLK_W = $clog2(NBLK),
    localparam int LOG_W = 2 * PID_W + 2 * IC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmt_valid,
    input  logic             cmt_is_mem,
    input  logic [BLK_W-1:0] cmt_blk,
    input  logic             req_valid,
    input  logic [BLK_W-1:0] req_blk,
    input  logic             req_inv,
    output logic             rsp_valid,
    output logic [IC_W-1:0]  rsp_cnt,
    output logic             rsp_is_ack,
    input  logic             rep_valid,
    input  logic [PID_W-1:0] rep_src,
    input  logic [IC_W-1:0]  rep_cnt,
    output logic             rep_ready,
    input  logic             log_full,
    output logic             log_valid,
    output logic [LOG_W-1:0] log_data
);
    localparam logic [PID_W-1:0] LID = PID_W'(LOCAL_ID);

    rec_state_e      state_q, state_d;
    logic [IC_W-1:0] ic;
    logic [IC_W-1:0] ic_next;
    logic [PID_W-1:0] cap_src;
    logic [IC_W-1:0] cap_cnt;
    logic [IC_W-1:0] cap_dst;
    logic [IC_W-1:0] vec_cnt;
    logic            take;
    logic            fresh;
    logic            vec_wr;

    assign ic_next = ic + 1'b1;

    rar_icount #(.IC_W(IC_W)) u_ic (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (cmt_valid),
        .count (ic)
    );

    rar_blk_table #(.NBLK(NBLK), .IC_W(IC_W)) u_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cmt_valid && cmt_is_mem),
        .wr_blk (cmt_blk),
        .wr_cnt (ic_next),
        .rd_en  (req_valid),
        .rd_blk (req_blk),
        .rd_cnt (rsp_cnt)
    );

    rar_vec #(.NPROC(NPROC), .IC_W(IC_W), .LOCAL_ID(LOCAL_ID)) u_vec (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (cap_src),
        .wr_en  (vec_wr),
        .wr_cnt (cap_cnt),
        .rd_cnt (vec_cnt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_is_ack <= 1'b0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_is_ack <= req_valid && req_inv;
        end
    end

    // reply capture
    assign take = rep_valid && rep_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_src <= '0;
            cap_cnt <= '0;
            cap_dst <= '0;
        end else if (take) begin
            cap_src <= rep_src;
            cap_cnt <= rep_cnt;
            cap_dst <= ic_next;
        end
    end

    assign fresh = (cap_src != LID) && (cap_cnt > vec_cnt);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        rep_ready = 1'b0;
        vec_wr    = 1'b0;
        log_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                rep_ready = 1'b1;
                if (rep_valid) state_d = ST_CMP;
            end
            ST_CMP: begin
                if (fresh) begin
                    vec_wr  = 1'b1;
                    state_d = ST_WRITE;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_WRITE: begin
                if (!log_full) begin
                    log_valid = 1'b1;
                    state_d   = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign log_data = {cap_src, cap_cnt, LID, cap_dst};
endmodule

// File: rtl/race_arc_rec_chk.sv
module race_arc_rec_chk #(
    parameter int IC_W  = 32,
    parameter int PID_W = 2,
    parameter int LOG_W = 68,
    parameter int LOCAL_ID = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmt_valid,
    input logic [IC_W-1:0]  ic,
    input logic             req_valid,
    input logic             req_inv,
    input logic             rsp_valid,
    input logic             rsp_is_ack,
    input logic             rep_ready,
    input logic             log_full,
    input logic             log_valid,
    input logic [LOG_W-1:0] log_data
);
    AST_IC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_valid |=> (ic == $past(ic) + 1'b1)); // R2
    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_valid && (rsp_is_ack == $past(req_inv)))); // R4
    AST_NO_SELF_LOG: assert property (@(posedge clk) disable iff (!rst_n)
        log_valid |-> (log_data[LOG_W-1 -: PID_W] != PID_W'(LOCAL_ID))); // R8
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        log_full |-> !log_valid); // R10
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rep_ready && log_full) |=> $stable(log_data)); // R10
    AST_BUSY_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        log_valid |-> !rep_ready); // R11
    AST_LOG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        log_valid |=> !log_valid); // R11
endmodule

bind race_arc_rec race_arc_rec_chk #(
    .IC_W(IC_W), .PID_W(PID_W), .LOG_W(LOG_W), .LOCAL_ID(LOCAL_ID)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmt_valid  (cmt_valid),
    .ic         (ic),
    .req_valid  (req_valid),
    .req_inv    (req_inv),
    .rsp_valid  (rsp_valid),
    .rsp_is_ack (rsp_is_ack),
    .rep_ready  (rep_ready),
    .log_full   (log_full),
    .log_valid  (log_valid),
    .log_data   (log_data)
);

// File: tb/race_arc_rec_tb.sv
module race_arc_rec_tb;
    localparam int NPROC = 4;
    localparam int NBLK  = 16;
    localparam int IC_W  = 32;
    localparam int LOCAL = 1;
    localparam int PID_W = 2;
    localparam int BLK_W = 4;
    localparam int LOG_W = 68;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmt_valid = 1'b0, cmt_is_mem = 1'b0;
    logic [BLK_W-1:0] cmt_blk = '0;
    logic req_valid = 1'b0, req_inv = 1'b0;
    logic [BLK_W-1:0] req_blk = '0;
    logic rsp_valid, rsp_is_ack, rep_ready, log_valid;
    logic [IC_W-1:0] rsp_cnt;
    logic rep_valid = 1'b0;
    logic [PID_W-1:0] rep_src = '0;
    logic [IC_W-1:0] rep_cnt = '0;
    logic log_full = 1'b0;
    logic [LOG_W-1:0] log_data;

    int nchk = 0;
    int nbad = 0;
    logic [IC_W-1:0] ic_m;
    logic [IC_W-1:0] tbl_m [NBLK];
    logic [IC_W-1:0] vec_m [NPROC];

    always #2.5 clk = ~clk;

    race_arc_rec #(.NPROC(NPROC), .NBLK(NBLK), .IC_W(IC_W), .LOCAL_ID(LOCAL)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cmt_valid(cmt_valid), .cmt_is_mem(cmt_is_mem), .cmt_blk(cmt_blk),
        .req_valid(req_valid), .req_blk(req_blk), .req_inv(req_inv),
        .rsp_valid(rsp_valid), .rsp_cnt(rsp_cnt), .rsp_is_ack(rsp_is_ack),
        .rep_valid(rep_valid), .rep_src(rep_src), .rep_cnt(rep_cnt), .rep_ready(rep_ready),
        .log_full(log_full), .log_valid(log_valid), .log_data(log_data)
    );

    task automatic chk(input logic ok, input string req, input logic [LOG_W-1:0] act,
                       input logic [LOG_W-1:0] exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_commit(input logic mem, input int blk);
        cmt_valid = 1'b1; cmt_is_mem = mem; cmt_blk = BLK_W'(blk);
        @(negedge clk);
        cmt_valid = 1'b0; cmt_is_mem = 1'b0;
        ic_m = ic_m + 1;
        if (mem) tbl_m[blk] = ic_m;
    endtask

    task automatic do_req(input int blk, input logic inv, input string tag);
        req_valid = 1'b1; req_blk = BLK_W'(blk); req_inv = inv;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid == 1'b1, {tag, " rsp_valid"}, LOG_W'(rsp_valid), 1);
        chk(rsp_cnt == tbl_m[blk], {tag, " rsp_cnt"}, LOG_W'(rsp_cnt), LOG_W'(tbl_m[blk]));
        chk(rsp_is_ack == inv, "R4 rsp_is_ack", LOG_W'(rsp_is_ack), LOG_W'(inv));
    endtask

    task automatic do_rep(input int src, input logic [IC_W-1:0] cnt, input string tag);
        logic exp_log;
        logic [LOG_W-1:0] exp_word;
        exp_log  = (src != LOCAL) && (cnt > vec_m[src]);
        exp_word = {PID_W'(src), cnt, PID_W'(LOCAL), ic_m + 32'd1};
        chk(rep_ready == 1'b1, "R5 rep_ready idle", LOG_W'(rep_ready), 1);
        rep_valid = 1'b1; rep_src = PID_W'(src); rep_cnt = cnt;
        @(negedge clk);
        rep_valid = 1'b0;
        chk(log_valid == 1'b0, "R11 no early log", LOG_W'(log_valid), 0);
        @(negedge clk);
        chk(log_valid == exp_log, {tag, " log_valid"}, LOG_W'(log_valid), LOG_W'(exp_log));
        if (exp_log) begin
            chk(log_data == exp_word, "R9 R5 log_data", log_data, exp_word);
            vec_m[src] = cnt;
            @(negedge clk);
            chk(log_valid == 1'b0, "R11 single pulse", LOG_W'(log_valid), 0);
        end
        chk(rep_ready == 1'b1, "R5 ready again", LOG_W'(rep_ready), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        ic_m = '0;
        for (int b = 0; b < NBLK; b++) tbl_m[b] = '0;
        for (int p = 0; p < NPROC; p++) vec_m[p] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(log_valid == 1'b0, "R1 log_valid", LOG_W'(log_valid), 0);
        chk(rep_ready == 1'b1, "R1 rep_ready", LOG_W'(rep_ready), 1);
        for (int b = 0; b < NBLK; b++) do_req(b, 1'b0, "R1");
        // R2 R3 commit sweep over every block with mixed non-memory commits
        for (int b = 0; b < NBLK; b++) begin
            for (int k = 0; k < (b % 3); k++) do_commit(1'b0, (b + 5) % NBLK);
            do_commit(1'b1, b);
        end
        for (int b = 0; b < NBLK; b++) do_req(b, b[0], "R3");
        for (int k = 0; k < 7; k++) do_commit(1'b0, k);
        for (int b = 0; b < NBLK; b++) do_req(b, ~b[0], "R3 nonmem");
        do_commit(1'b1, 4);
        do_commit(1'b1, 4);
        do_req(4, 1'b1, "R2");
        // R6 R7 R8 reply sweep
        for (int s = 0; s < NPROC; s++) begin
            do_rep(s, 32'd5, "R6");
            do_rep(s, 32'd5, "R7 equal");
            do_rep(s, 32'd3, "R7 lower");
            do_rep(s, 32'd9, "R6 higher");
            do_commit(1'b0, 0);
            do_rep(s, 32'd0, "R7 zero");
            do_rep(s, 32'hFFFF_FFFF, "R6 max");
            do_rep(s, 32'hFFFF_FFFF, "R7 max again");
        end
        do_rep(LOCAL, 32'd77, "R8");
        // R10 log full stall
        do_commit(1'b0, 0);
        vec_m[2] = 32'hFFFF_FFFF;
        log_full = 1'b1;
        rep_valid = 1'b1; rep_src = 2'd3; rep_cnt = 32'd1;
        vec_m[3] = 32'hFFFF_FFFF;
        @(negedge clk);
        rep_valid = 1'b0;
        @(negedge clk);
        chk(log_valid == 1'b0, "R10 no log (pruned)", LOG_W'(log_valid), 0);
        // a kept arc from processor 0 while full: vector holds max, so use source 2 path via fresh counts impossible; exercise with source 0 after reset
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        ic_m = '0;
        for (int p = 0; p < NPROC; p++) vec_m[p] = '0;
        for (int b = 0; b < NBLK; b++) tbl_m[b] = '0;
        do_req(7, 1'b0, "R1 after rerun");
        rep_valid = 1'b1; rep_src = 2'd0; rep_cnt = 32'd40;
        @(negedge clk);
        rep_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(log_valid == 1'b0, "R10 held low", LOG_W'(log_valid), 0);
            chk(rep_ready == 1'b0, "R10 not ready", LOG_W'(rep_ready), 0);
        end
        log_full = 1'b0;
        #1;
        chk(log_valid == 1'b1, "R10 released", LOG_W'(log_valid), 1);
        chk(log_data == {2'd0, 32'd40, 2'd1, 32'd1}, "R10 R9 held entry", log_data,
            {2'd0, 32'd40, 2'd1, 32'd1});
        @(negedge clk);
        chk(rep_ready == 1'b1, "R10 ready after drain", LOG_W'(rep_ready), 1);
        vec_m[0] = 32'd40;
        do_rep(0, 32'd40, "R7 after drain");
        do_rep(0, 32'd41, "R6 after drain");
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule